// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This block holds the interrupt state of a serial port. Each cycle it compares the receive and transmit FIFO occupancy counts with two programmable trigger levels and forms a live status word of occupancy flags. Those flags, together with single-cycle error event pulses from the receive and transmit paths, collect in a sticky status word. Software clears the sticky word by writing ones to the bits it wants cleared.

An interrupt mask selects which sticky bits can raise the single level interrupt. Software does not write the mask directly. One write-only register sets mask bits and a second one clears them. The interrupt output is registered. The FIFOs, the serializer, the baud generator and any bus protocol wrapper sit outside this block and connect through the count inputs, the event inputs and a simple single-cycle register port.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (address 0x4, read-only) is a combinational function of the counts and trigger levels:
  - bit0 is set when rx count >= rx level.
  - bit1 is set when rx count == 0.
  - bit2 is set when rx count == FIFO_DEPTH.
  - bit3 is set when tx count == 0.
  - bit4 is set when tx count == FIFO_DEPTH.
  - bit13 is set when tx count >= tx level.
  - All other bits read 0.
- R2: At every clock edge, live bits 4:0 are ORed into sticky bits 4:0 and live bit13 is ORed into sticky bit10. A sticky bit stays set after its live source goes low.
- R3: A one-cycle event pulse sets a sticky bit at the next edge:
  - rx overrun sets bit5.
  - framing error sets bit6.
  - parity error sets bit7.
  - rx timeout sets bit8.
  - modem status change sets bit9.
  - tx overflow sets bit12.
  - Sticky bit11 is always 0.
- R4: A write to the sticky status (address 0x3) clears every bit written as 1 and leaves the other bits unchanged.
- R5: When a set source (an event or a live flag) and a write-1-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R6: A write to the enable register (address 0x0) ORs the written value into the mask. Only bits 0–10 and 12 are stored.
- R7: A write to the disable register (address 0x1) clears from the mask every bit written as 1.
- R8: Writes to the mask address (0x2) and to the live status address (0x4) have no effect.
- R9: irq_o is high exactly when (mask AND sticky) is nonzero. It follows the registered mask and sticky state with one cycle of delay.
- R10: After reset the mask and sticky words are 0, both trigger levels are 32 and irq_o is 0.
- R11: The rx trigger level (address 0x5) and the tx trigger level (address 0x6) are read/write and hold the low CNT_W bits of the written data.
- R12: The enable and disable addresses and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_cnt_i | input | CNT_W | Receive FIFO occupancy |
| tx_cnt_i | input | CNT_W | Transmit FIFO occupancy |
| rx_ovr_i | input | 1 | Receive overrun event pulse |
| frame_err_i | input | 1 | Framing error event pulse |
| parity_err_i | input | 1 | Parity error event pulse |
| rx_timeout_i | input | 1 | Receive timeout event pulse |
| modem_chg_i | input | 1 | Modem status change event pulse |
| tx_ovf_i | input | 1 | Transmit overflow event pulse |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the counts never exceed FIFO_DEPTH and that a write to one register is a single-cycle strobe with a stable address and data. They do not depend on the event inputs being single pulses, because a held event simply keeps its sticky bit set. The stimulus changes every input on the falling clock edge, keeps the counts within 0..FIFO_DEPTH and raises the write strobe for exactly one cycle per access. It returns the counts to a quiet setting (neither empty, full nor at a trigger level) before any sticky bit is expected to clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned LIVE_W   = 14;
  localparam int unsigned STICKY_W = 13;

  // live status positions
  localparam int unsigned LB_RX_TRIG  = 0;
  localparam int unsigned LB_RX_EMPTY = 1;
  localparam int unsigned LB_RX_FULL  = 2;
  localparam int unsigned LB_TX_EMPTY = 3;
  localparam int unsigned LB_TX_FULL  = 4;
  localparam int unsigned LB_TX_TRIG  = 13;

  // sticky status positions (bits 4:0 mirror live)
  localparam int unsigned SB_RX_OVR  = 5;
  localparam int unsigned SB_FRAME   = 6;
  localparam int unsigned SB_PARITY  = 7;
  localparam int unsigned SB_TIMEOUT = 8;
  localparam int unsigned SB_MODEM   = 9;
  localparam int unsigned SB_TX_TRIG = 10;
  localparam int unsigned SB_TX_OVF  = 12;

  localparam logic [STICKY_W-1:0] STICKY_VALID = 13'h17FF;

  typedef enum logic [ADDR_W-1:0] {
    A_IRQ_SET = 4'h0,
    A_IRQ_CLR = 4'h1,
    A_MASK    = 4'h2,
    A_STICKY  = 4'h3,
    A_LIVE    = 4'h4,
    A_RX_LVL  = 4'h5,
    A_TX_LVL  = 4'h6
  } reg_addr_e;

  typedef struct packed {
    logic tx_ovf;
    logic modem_chg;
    logic rx_timeout;
    logic parity_err;
    logic frame_err;
    logic rx_ovr;
  } evt_t;
endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = 7
) (
  input  logic [1:0][CNT_W-1:0] cnt_i,  // [0] rx, [1] tx
  input  logic [1:0][CNT_W-1:0] lvl_i,
  output logic [LIVE_W-1:0]     live_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [1:0] empty, full, trig;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign empty[d] = (cnt_i[d] == '0);
    assign full[d]  = (cnt_i[d] == FULL_CNT);
    assign trig[d]  = (cnt_i[d] >= lvl_i[d]);
  end

  always_comb begin
    live_o              = '0;
    live_o[LB_RX_TRIG]  = trig[0];
    live_o[LB_RX_EMPTY] = empty[0];
    live_o[LB_RX_FULL]  = full[0];
    live_o[LB_TX_EMPTY] = empty[1];
    live_o[LB_TX_FULL]  = full[1];
    live_o[LB_TX_TRIG]  = trig[1];
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LIVE_W-1:0]   live_i,
  input  evt_t                evt_i,
  input  logic                set_we_i,
  input  logic                clr_we_i,
  input  logic                ack_we_i,
  input  logic [STICKY_W-1:0] wdata_i,
  output logic [STICKY_W-1:0] mask_o,
  output logic [STICKY_W-1:0] sticky_o
);
  logic [STICKY_W-1:0] set_word, sticky_d, sticky_q, mask_d, mask_q;

  always_comb begin
    set_word             = '0;
    set_word[4:0]        = live_i[4:0];
    set_word[SB_TX_TRIG] = live_i[LB_TX_TRIG];
    set_word[SB_RX_OVR]  = evt_i.rx_ovr;
    set_word[SB_FRAME]   = evt_i.frame_err;
    set_word[SB_PARITY]  = evt_i.parity_err;
    set_word[SB_TIMEOUT] = evt_i.rx_timeout;
    set_word[SB_MODEM]   = evt_i.modem_chg;
    set_word[SB_TX_OVF]  = evt_i.tx_ovf;
  end

  // set sources take priority over a same-cycle clear
  assign sticky_d = (sticky_q & ~(ack_we_i ? wdata_i : '0)) | set_word;

  always_comb begin
    mask_d = mask_q;
    if (set_we_i)      mask_d = mask_q | (wdata_i & STICKY_VALID);
    else if (clr_we_i) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      mask_q   <= mask_d;
    end
  end

  assign mask_o   = mask_q;
  assign sticky_o = sticky_q;

  // R2
  live_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i[4:0] != '0) |=> ((sticky_q[4:0] & $past(live_i[4:0])) == $past(live_i[4:0])));
  // R2
  tx_trig_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i[LB_TX_TRIG] |=> sticky_q[SB_TX_TRIG]);
  // R3
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (sticky_q[SB_RX_OVR] || !$past(evt_i.rx_ovr)) && (sticky_q[SB_TX_OVF] || !$past(evt_i.tx_ovf)));
  // R3
  spare_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !sticky_q[11]);
  // R4
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_we_i |=> ((sticky_q & $past(wdata_i & ~set_word)) == '0));
  // R6
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((mask_q & $past(wdata_i & STICKY_VALID)) == $past(wdata_i & STICKY_VALID)));
  // R7
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(wdata_i)) == '0));
  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned TRIG_RST = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [STICKY_W-1:0]   mask_i,
  input  logic [STICKY_W-1:0]   sticky_i,
  input  logic [LIVE_W-1:0]     live_i,
  output logic                  set_we_o,
  output logic                  clr_we_o,
  output logic                  ack_we_o,
  output logic [STICKY_W-1:0]   wbits_o,
  output logic [1:0][CNT_W-1:0] lvl_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam logic [CNT_W-1:0] LVL_RST = CNT_W'(TRIG_RST);

  logic [1:0][CNT_W-1:0] lvl_q;
  logic [1:0]            lvl_we;
  logic                  unused_wdata;

  assign set_we_o = we_i && (addr_i == A_IRQ_SET);
  assign clr_we_o = we_i && (addr_i == A_IRQ_CLR);
  assign ack_we_o = we_i && (addr_i == A_STICKY);
  assign wbits_o  = wdata_i[STICKY_W-1:0];
  assign lvl_we[0] = we_i && (addr_i == A_RX_LVL);
  assign lvl_we[1] = we_i && (addr_i == A_TX_LVL);
  assign unused_wdata = ^wdata_i;

  for (genvar d = 0; d < 2; d++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lvl_q[d] <= LVL_RST;
      else if (lvl_we[d]) lvl_q[d] <= wdata_i[CNT_W-1:0];
    end

    // R11
    lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lvl_we[d] |=> $stable(lvl_q[d]));
  end

  assign lvl_o = lvl_q;

  always_comb begin
    unique case (addr_i)
      A_MASK:   rdata_o = DATA_W'(mask_i);
      A_STICKY: rdata_o = DATA_W'(sticky_i);
      A_LIVE:   rdata_o = DATA_W'(live_i);
      A_RX_LVL: rdata_o = DATA_W'(lvl_q[0]);
      A_TX_LVL: rdata_o = DATA_W'(lvl_q[1]);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TRIG_RST   = 32,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              rx_ovr_i,
  input  logic              frame_err_i,
  input  logic              parity_err_i,
  input  logic              rx_timeout_i,
  input  logic              modem_chg_i,
  input  logic              tx_ovf_i,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [1:0][CNT_W-1:0] cnt, lvl;
  logic [LIVE_W-1:0]     live;
  logic [STICKY_W-1:0]   mask, sticky, wbits;
  logic                  set_we, clr_we, ack_we, irq_q;
  evt_t                  evt;

  assign cnt[0] = rx_cnt_i;
  assign cnt[1] = tx_cnt_i;
  assign evt    = '{tx_ovf: tx_ovf_i, modem_chg: modem_chg_i, rx_timeout: rx_timeout_i,
                    parity_err: parity_err_i, frame_err: frame_err_i, rx_ovr: rx_ovr_i};

  uart_irq_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
    .cnt_i (cnt),
    .lvl_i (lvl),
    .live_o(live)
  );

  uart_irq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TRIG_RST(TRIG_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mask_i  (mask),
    .sticky_i(sticky),
    .live_i  (live),
    .set_we_o(set_we),
    .clr_we_o(clr_we),
    .ack_we_o(ack_we),
    .wbits_o (wbits),
    .lvl_o   (lvl),
    .rdata_o (reg_rdata_o)
  );

  uart_irq_sticky u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .live_i  (live),
    .evt_i   (evt),
    .set_we_i(set_we),
    .clr_we_i(clr_we),
    .ack_we_i(ack_we),
    .wdata_i (wbits),
    .mask_o  (mask),
    .sticky_o(sticky)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(mask & sticky);
  end

  assign irq_o = irq_q;

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(mask & sticky)));
  // R1
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(live[LB_RX_FULL] && live[LB_RX_EMPTY]) && !(live[LB_TX_FULL] && live[LB_TX_EMPTY]));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_cnt = '0;
  logic             rx_ovr = 0, frame_err = 0, parity_err = 0, rx_timeout = 0, modem_chg = 0, tx_ovf = 0;
  logic             we = 0;
  logic [3:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq;
  int               checks = 0, failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .rx_ovr_i(rx_ovr), .frame_err_i(frame_err), .parity_err_i(parity_err),
    .rx_timeout_i(rx_timeout), .modem_chg_i(modem_chg), .tx_ovf_i(tx_ovf),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic quiet();
    @(negedge clk);
    rx_cnt = 5; tx_cnt = 5;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 irq", 32'(irq), 0);
    rd(4'h2, v); chk("R10 mask", v, 0);
    rd(4'h3, v); chk("R10 sticky", v, 0);
    rd(4'h5, v); chk("R10 rx level", v, 32);
    rd(4'h6, v); chk("R10 tx level", v, 32);
    rd(4'h4, v); chk("R1 live at empty", v, 32'h000A);
    rd(4'h0, v); chk("R12 enable reads 0", v, 0);
    rd(4'h1, v); chk("R12 disable reads 0", v, 0);
    rd(4'hF, v); chk("R12 unmapped reads 0", v, 0);
    @(negedge clk);
    rd(4'h3, v); chk("R2 sticky after first edge", v, 32'h000A);
  endtask

  task automatic t_live();
    logic [31:0] v;
    @(negedge clk); rx_cnt = 32; tx_cnt = 64;
    rd(4'h4, v); chk("R1 rx at level tx full", v, 32'h2011);
    @(negedge clk); rx_cnt = 64; tx_cnt = 31;
    rd(4'h4, v); chk("R1 rx full tx below", v, 32'h0005);
    @(negedge clk); rx_cnt = 31; tx_cnt = 0;
    rd(4'h4, v); chk("R1 tx empty", v, 32'h0008);
    wr(4'h5, 32'h0);
    rd(4'h5, v); chk("R11 rx level write", v, 0);
    @(negedge clk); rx_cnt = 0;
    rd(4'h4, v); chk("R1 level zero", v, 32'h000B);
    wr(4'h6, 32'h1FF);
    rd(4'h6, v); chk("R11 tx level truncated", v, 32'h7F);
    wr(4'h4, 32'hFFFF);
    rd(4'h4, v); chk("R8 live write ignored", v, 32'h000B);
    wr(4'h5, 32); wr(4'h6, 32);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    quiet();
    wr(4'h3, 32'h1FFF);
    rd(4'h3, v); chk("R4 clear all", v, 0);
    @(negedge clk); rx_cnt = 40; tx_cnt = 40;
    @(negedge clk);
    rd(4'h3, v); chk("R2 trig latch", v, 32'h0401);
    quiet();
    rd(4'h3, v); chk("R2 retained", v, 32'h0401);
    wr(4'h3, 32'h0400);
    rd(4'h3, v); chk("R4 partial clear", v, 32'h0001);
    wr(4'h3, 32'h0001);
  endtask

  task automatic t_events();
    logic [31:0] v;
    @(negedge clk); rx_ovr = 1;     @(negedge clk); rx_ovr = 0;
    rd(4'h3, v); chk("R3 overrun", v, 32'h0020);
    @(negedge clk); frame_err = 1;  @(negedge clk); frame_err = 0;
    @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
    @(negedge clk); rx_timeout = 1; @(negedge clk); rx_timeout = 0;
    @(negedge clk); modem_chg = 1;  @(negedge clk); modem_chg = 0;
    @(negedge clk); tx_ovf = 1;     @(negedge clk); tx_ovf = 0;
    rd(4'h3, v); chk("R3 all events", v, 32'h13E0);
    wr(4'h3, 32'h0860);
    rd(4'h3, v); chk("R4 clear subset", v, 32'h1380);
    wr(4'h3, 32'h1FFF);
    rd(4'h3, v); chk("R4 clear rest", v, 0);
    @(negedge clk);
    we = 1; addr = 4'h3; wdata = 32'h0100; rx_timeout = 1;
    @(negedge clk);
    we = 0; rx_timeout = 0;
    rd(4'h3, v); chk("R5 event beats clear", v, 32'h0100);
    wr(4'h3, 32'h0100);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'h0, 32'h0021); rd(4'h2, v); chk("R6 enable", v, 32'h0021);
    wr(4'h0, 32'h0100); rd(4'h2, v); chk("R6 enable accumulates", v, 32'h0121);
    wr(4'h1, 32'h0001); rd(4'h2, v); chk("R7 disable", v, 32'h0120);
    wr(4'h2, 32'h1FFF); rd(4'h2, v); chk("R8 mask write ignored", v, 32'h0120);
    wr(4'h0, 32'hFFFF); rd(4'h2, v); chk("R6 stored bits only", v, 32'h17FF);
    wr(4'h1, 32'hFFFF); rd(4'h2, v); chk("R7 disable all", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(4'h0, 32'h0020);
    chk("R9 masked but clear", 32'(irq), 0);
    @(negedge clk); rx_ovr = 1; @(negedge clk); rx_ovr = 0;
    rd(4'h3, v); chk("R3 overrun for irq", v, 32'h0020);
    chk("R9 irq one cycle late", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq raised", 32'(irq), 1);
    wr(4'h1, 32'h0020);
    chk("R9 irq held one cycle", 32'(irq), 1);
    @(negedge clk);
    chk("R9 irq dropped", 32'(irq), 0);
    wr(4'h3, 32'h0020);
    @(negedge clk); rx_cnt = 0;
    wr(4'h0, 32'h0002);
    @(negedge clk);
    chk("R9 irq from live flag", 32'(irq), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_live();
    t_sticky();
    t_events();
    t_mask();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule